// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the byte-wide receive path after the MAC and decides, frame by frame, whether a frame goes on to the rest of the chip. It takes the first six bytes of each frame as the 48-bit destination address. It then looks for that address in a small programmable table, one entry per clock cycle. A polarity bit selects whether a hit keeps the frame or discards it. A third setting turns filtering off: every frame passes, and it is still tagged. Every frame that passes gets one extra byte after its last byte. That byte is the tag stored with the matching table entry, or, when no entry matched, the tag byte presented on an input pin.

While the address is being captured and searched, frame bytes wait in a small delay buffer. Once the decision is known, the buffer is drained to the output or discarded. Software loads table entries and control settings through a simple write port. Writes that arrive while a lookup is running are ignored, so the table and settings cannot change under the search.

The controller has six states. IDLE waits for a start marker. ADDR collects address bytes. SEARCH walks the table. PASS forwards buffered bytes. DROP discards buffered bytes. TAG emits the appended byte. The transitions are as follows:
- IDLE→ADDR when a first byte arrives without an end marker.
- IDLE→PASS or IDLE→DROP for a one-byte frame.
- ADDR→SEARCH when the sixth byte is taken.
- ADDR→PASS or ADDR→DROP when the end marker arrives before the sixth byte.
- SEARCH→PASS or SEARCH→DROP on a hit or when the last active entry has been tried.
- PASS→TAG when the frame's last byte leaves.
- DROP→IDLE when the frame's last byte is discarded.
- TAG→IDLE after the tag byte.

Top module: `eth_da_filter`

## Requirements
- R1: While reset is asserted and afterwards with no input, out_valid stays low. After reset the settings are filter on, hit-keeps polarity and zero active entries, so every frame is discarded.
- R2: The destination address is the first six frame bytes, and the first byte forms address bits 47:40. A hit needs all 48 bits to equal a table entry.
- R3: With filtering on and ctl_reject=0, a frame that hits is forwarded and a frame that misses produces no output bytes at all.
- R4: With filtering on and ctl_reject=1, a frame that hits produces no output bytes, and a frame that misses is forwarded.
- R5: A forwarded frame appears unchanged and in order. out_sof is high on its first byte only. It is followed by exactly one extra byte, and out_eof is high on that extra byte only.
- R6: The extra byte is the tag stored with the hit entry when the address hit. When the address missed, it is the ext_tag value.
- R7: With ctl_filter_en=0 every frame is forwarded, tagged as in R6.
- R8: Group addresses (bit 0 of the first byte set) hit exactly like individual addresses. An address differing from an entry only in that bit misses.
- R9: Only entries 0 to count-1 are searched, one per cycle, where count is the value written to ctl_count. A count of 0 means nothing can hit, and a count above NUM_ENTRIES acts as NUM_ENTRIES.
- R10: A frame that ends before its sixth byte never hits. It is forwarded with ext_tag unless filtering is on with ctl_reject=0, in which case it is discarded.
- R11: Writes to the table and to the control settings are ignored from the cycle after a frame's first byte is taken until its decision is made. Writes at other times take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Receive byte present this cycle |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| ext_tag | input | 8 | Tag appended when no table entry hit |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_mac | input | 48 | Address value for the entry |
| tbl_tag | input | 8 | Tag value for the entry |
| ctl_we | input | 1 | Control settings write strobe |
| ctl_count | input | IDX_W | Number of active entries |
| ctl_filter_en | input | 1 | 1 = filter, 0 = forward all and tag |
| ctl_reject | input | 1 | 0 = hit keeps frame, 1 = hit discards frame |
| out_valid | output | 1 | Output byte present this cycle |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a forwarded frame |
| out_eof | output | 1 | Appended tag byte, the last byte out |

## Verification
The block has no backpressure and no way to accept a second frame while the first is still draining. The assertions therefore assume three things about the input. A start marker arrives only when the controller is back in IDLE. Bytes keep their start and end markers in pairs. ext_tag is steady while a frame is in flight. Under those assumptions the delay buffer can never overflow or underflow, and the search index never passes the active count. The stimulus sends each frame as a back-to-back burst with matching markers and holds ext_tag fixed for the frame. It then leaves enough idle cycles for the longest search, the drain and the tag byte before the next start marker. Writes during a lookup are placed well inside the address-capture window.

// File: rtl/eth_daf_pkg.sv
package eth_daf_pkg;

    localparam int MAC_W = 48;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SEARCH,
        ST_PASS,
        ST_DROP,
        ST_TAG
    } daf_state_e;

    typedef struct packed {
        logic [MAC_W-1:0] mac;
        logic [7:0]       tag;
    } daf_entry_t;

endpackage

// File: rtl/eth_daf_fifo.sv
module eth_daf_fifo #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_LVL = (PTR_W+1)'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [PTR_W:0]    level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            level <= level + {{PTR_W{1'b0}}, push} - {{PTR_W{1'b0}}, pop};
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= push_data;
    end

    assign head  = mem[rp];
    assign empty = (level == '0);
    assign full  = (level == FULL_LVL);

    // R5: the delay buffer never loses or invents a frame byte
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/eth_daf_table.sv
module eth_daf_table
    import eth_daf_pkg::*;
#(
    parameter int ENTRIES = 24,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [MAC_W-1:0] wr_mac,
    input  logic [7:0]       wr_tag,
    input  logic             lock,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [MAC_W-1:0] rd_mac,
    output logic [7:0]       rd_tag
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ENTRIES - 1);

    daf_entry_t ent [ENTRIES];
    daf_entry_t rd_ent;
    logic       wr_ok;

    // R11: a write is taken only while no lookup is running
    assign wr_ok = wr_en && !lock && (wr_idx <= TOP_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) ent[k] <= '0;
        end else if (wr_ok) begin
            ent[wr_idx] <= '{mac: wr_mac, tag: wr_tag};
        end
    end

    assign rd_ent = (rd_idx <= TOP_IDX) ? ent[rd_idx] : '0;
    assign rd_mac = rd_ent.mac;
    assign rd_tag = rd_ent.tag;

    // R11: the entry under inspection holds still through a lookup
    a_r11_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock) && rd_idx == $past(rd_idx)) |-> ($stable(rd_mac) && $stable(rd_tag)));

endmodule

// File: rtl/eth_daf_fsm.sv
module eth_daf_fsm
    import eth_daf_pkg::*;
#(
    parameter int ENTRIES = 24,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       ext_tag,
    input  logic             ctl_we,
    input  logic [IDX_W-1:0] ctl_count,
    input  logic             ctl_filter_en,
    input  logic             ctl_reject,
    output logic             fifo_push,
    output logic             fifo_pop,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_byte,
    input  logic             fifo_last,
    output logic [IDX_W-1:0] tbl_rd_idx,
    input  logic [MAC_W-1:0] tbl_rd_mac,
    input  logic [7:0]       tbl_rd_tag,
    output logic             lookup_busy,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof
);
    localparam logic [IDX_W-1:0] MAX_CNT = IDX_W'(ENTRIES);
    localparam logic [IDX_W-1:0] ONE     = IDX_W'(1);

    daf_state_e       state, state_d;
    logic             in_frame;
    logic [MAC_W-1:0] addr_q, addr_next;
    logic [2:0]       nbytes;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] cnt_q;
    logic             filt_q, rej_q;
    logic [7:0]       tag_q;
    logic             first_q;
    logic             decide, dec_accept;
    logic [7:0]       dec_tag;
    logic             take;

    assign addr_next = {addr_q[MAC_W-9:0], in_data};
    assign take      = in_valid && (in_frame || in_sof);

    // Next state and decision
    always_comb begin
        state_d    = state;
        decide     = 1'b0;
        dec_accept = 1'b0;
        dec_tag    = ext_tag;
        unique case (state)
            ST_IDLE: begin
                if (take && in_sof) begin
                    if (in_eof) begin
                        decide     = 1'b1;
                        dec_accept = !filt_q || rej_q;
                    end else begin
                        state_d = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (take) begin
                    if (nbytes == 3'd5) begin
                        state_d = ST_SEARCH;
                    end else if (in_eof) begin
                        decide     = 1'b1;
                        dec_accept = !filt_q || rej_q;
                    end
                end
            end
            ST_SEARCH: begin
                if (cnt_q != '0 && tbl_rd_mac == addr_q) begin
                    decide     = 1'b1;
                    dec_accept = !filt_q || !rej_q;
                    dec_tag    = tbl_rd_tag;
                end else if (cnt_q == '0 || idx == cnt_q - ONE) begin
                    decide     = 1'b1;
                    dec_accept = !filt_q || rej_q;
                end
            end
            ST_PASS: begin
                if (!fifo_empty && fifo_last) state_d = ST_TAG;
            end
            ST_DROP: begin
                if (!fifo_empty && fifo_last) state_d = ST_IDLE;
            end
            ST_TAG: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (decide) state_d = dec_accept ? ST_PASS : ST_DROP;
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            in_frame <= 1'b0;
            addr_q   <= '0;
            nbytes   <= '0;
            idx      <= '0;
            cnt_q    <= '0;
            filt_q   <= 1'b1;
            rej_q    <= 1'b0;
            tag_q    <= '0;
            first_q  <= 1'b0;
        end else begin
            state <= state_d;
            if (take) in_frame <= !in_eof;
            if (state == ST_IDLE && take && in_sof) begin
                addr_q <= addr_next;
                nbytes <= 3'd1;
            end else if (state == ST_ADDR && take) begin
                addr_q <= addr_next;
                nbytes <= nbytes + 3'd1;
            end
            idx <= (state == ST_SEARCH && !decide) ? idx + ONE : '0;
            if (decide) begin
                tag_q   <= dec_tag;
                first_q <= 1'b1;
            end else if (state == ST_PASS && !fifo_empty) begin
                first_q <= 1'b0;
            end
            if (ctl_we && !lookup_busy) begin
                cnt_q  <= (ctl_count > MAX_CNT) ? MAX_CNT : ctl_count;
                filt_q <= ctl_filter_en;
                rej_q  <= ctl_reject;
            end
        end
    end

    // Outputs
    always_comb begin
        fifo_push   = take;
        fifo_pop    = 1'b0;
        lookup_busy = 1'b0;
        tbl_rd_idx  = idx;
        out_valid   = 1'b0;
        out_data    = fifo_byte;
        out_sof     = 1'b0;
        out_eof     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_ADDR:   lookup_busy = 1'b1;
            ST_SEARCH: lookup_busy = 1'b1;
            ST_PASS: begin
                fifo_pop  = !fifo_empty;
                out_valid = !fifo_empty;
                out_sof   = !fifo_empty && first_q;
            end
            ST_DROP: fifo_pop = !fifo_empty;
            ST_TAG: begin
                out_valid = 1'b1;
                out_data  = tag_q;
                out_eof   = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: the tag byte closes the frame and is followed by a quiet cycle
    a_r5_tag_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |=> !out_valid);
    // R5: only one start marker per forwarded frame
    a_r5_single_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |=> !out_sof);
    // R9: the search never looks past the active count
    a_r9_search_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && cnt_q != '0) |-> (idx < cnt_q));
    // R11: settings hold still during a lookup
    a_r11_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_busy && $past(lookup_busy)) |-> ($stable(cnt_q) && $stable(filt_q) && $stable(rej_q)));
    // R3: a discarded frame sends nothing out
    a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DROP && state != ST_PASS) |-> !out_valid);

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
    import eth_daf_pkg::*;
#(
    parameter int  NUM_ENTRIES = 24,
    parameter int  FIFO_DEPTH  = 32,
    localparam int IDX_W       = $clog2(NUM_ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       ext_tag,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [47:0]      tbl_mac,
    input  logic [7:0]       tbl_tag,
    input  logic             ctl_we,
    input  logic [IDX_W-1:0] ctl_count,
    input  logic             ctl_filter_en,
    input  logic             ctl_reject,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof
);
    logic             f_push, f_pop, f_empty, f_full;
    logic [8:0]       f_head;
    logic [IDX_W-1:0] rd_idx;
    logic [MAC_W-1:0] rd_mac;
    logic [7:0]       rd_tag;
    logic             busy;

    eth_daf_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(9)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push),
        .push_data ({in_eof, in_data}),
        .pop       (f_pop),
        .head      (f_head),
        .empty     (f_empty),
        .full      (f_full)
    );

    eth_daf_table #(.ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_idx (tbl_idx),
        .wr_mac (tbl_mac),
        .wr_tag (tbl_tag),
        .lock   (busy),
        .rd_idx (rd_idx),
        .rd_mac (rd_mac),
        .rd_tag (rd_tag)
    );

    eth_daf_fsm #(.ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .ext_tag       (ext_tag),
        .ctl_we        (ctl_we),
        .ctl_count     (ctl_count),
        .ctl_filter_en (ctl_filter_en),
        .ctl_reject    (ctl_reject),
        .fifo_push     (f_push),
        .fifo_pop      (f_pop),
        .fifo_empty    (f_empty),
        .fifo_byte     (f_head[7:0]),
        .fifo_last     (f_head[8]),
        .tbl_rd_idx    (rd_idx),
        .tbl_rd_mac    (rd_mac),
        .tbl_rd_tag    (rd_tag),
        .lookup_busy   (busy),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .out_sof       (out_sof),
        .out_eof       (out_eof)
    );

    // R1: nothing leaves the block while reset holds it
    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |-> !out_valid);
    // R5: the buffer full flag is never reached under legal traffic
    a_r5_buffer_room: assert property (@(posedge clk) disable iff (!rst_n)
        f_push |-> !f_full);

endmodule

// File: tb/eth_da_filter_test.sv
module eth_da_filter_test;

    typedef struct packed {
        logic        filt;
        logic        rej;
        logic [4:0]  cnt;
        logic [47:0] mac;
        logic [7:0]  len;
        logic [7:0]  ext;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 5'd24, 48'h020000000000, 8'd10, 8'h11}, // R3 R6 hit entry 0
        '{1'b1, 1'b0, 5'd24, 48'h020000000063, 8'd10, 8'h11}, // R3 miss, dropped
        '{1'b1, 1'b0, 5'd24, 48'h01005E000001, 8'd8,  8'h12}, // R8 group hit entry 1
        '{1'b1, 1'b0, 5'd24, 48'h030000000000, 8'd9,  8'h13}, // R8 R2 group bit differs
        '{1'b1, 1'b0, 5'd24, 48'h020000000017, 8'd64, 8'h14}, // R9 R5 last entry, long frame
        '{1'b1, 1'b0, 5'd5,  48'h020000000007, 8'd12, 8'h15}, // R9 beyond count
        '{1'b1, 1'b0, 5'd5,  48'h020000000004, 8'd12, 8'h16}, // R9 last active entry
        '{1'b1, 1'b1, 5'd24, 48'h020000000003, 8'd12, 8'h17}, // R4 hit, dropped
        '{1'b1, 1'b1, 5'd24, 48'h020000000063, 8'd12, 8'h5A}, // R4 R6 miss, ext tag
        '{1'b0, 1'b0, 5'd24, 48'h020000000063, 8'd12, 8'h3C}, // R7 miss passes
        '{1'b0, 1'b1, 5'd24, 48'h020000000002, 8'd12, 8'h3D}, // R7 hit passes with entry tag
        '{1'b1, 1'b0, 5'd0,  48'h020000000000, 8'd12, 8'h18}, // R9 zero count
        '{1'b1, 1'b1, 5'd0,  48'h020000000000, 8'd12, 8'h19}, // R9 zero count, reject polarity
        '{1'b1, 1'b0, 5'd31, 48'h020000000017, 8'd12, 8'h1A}, // R9 count clamps
        '{1'b1, 1'b0, 5'd24, 48'h020000000000, 8'd4,  8'h1B}, // R10 short, dropped
        '{1'b1, 1'b1, 5'd24, 48'h020000000000, 8'd3,  8'h1C}, // R10 short, passed
        '{1'b0, 1'b0, 5'd24, 48'h020000000000, 8'd1,  8'h1D}, // R10 one-byte frame
        '{1'b1, 1'b0, 5'd24, 48'h050000000002, 8'd8,  8'h1E}, // R2 byte order
        '{1'b1, 1'b0, 5'd24, 48'h020000000005, 8'd6,  8'h1F}  // R2 exactly six bytes
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0, ext_tag = '0;
    logic       tbl_we = 1'b0;
    logic [4:0] tbl_idx = '0;
    logic [47:0] tbl_mac = '0;
    logic [7:0] tbl_tag = '0;
    logic       ctl_we = 1'b0, ctl_filter_en = 1'b0, ctl_reject = 1'b0;
    logic [4:0] ctl_count = '0;
    logic       out_valid, out_sof, out_eof;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    int on = 0;
    logic [7:0] obuf [256];
    logic       osof [256];
    logic       oeof [256];

    always #2 clk = ~clk;

    eth_da_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .ext_tag(ext_tag),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_mac(tbl_mac), .tbl_tag(tbl_tag),
        .ctl_we(ctl_we), .ctl_count(ctl_count), .ctl_filter_en(ctl_filter_en),
        .ctl_reject(ctl_reject), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && on < 256) begin
            obuf[on] = out_data;
            osof[on] = out_sof;
            oeof[on] = out_eof;
            on++;
        end
    end

    function automatic logic [47:0] mac_of(int k);
        return (k == 1) ? 48'h01005E000001 : {40'h0200000000, 8'(k)};
    endfunction

    function automatic logic [7:0] tag_of(int k);
        return 8'(8'h80 + k);
    endfunction

    function automatic logic [7:0] fb(vec_t v, int i);
        if (i < 6) return 8'(v.mac >> (8 * (5 - i)));
        return 8'(8'h40 + i);
    endfunction

    task automatic check(bit ok, string rq, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_ctl(logic f, logic r, logic [4:0] c);
        @(negedge clk);
        ctl_we = 1'b1; ctl_filter_en = f; ctl_reject = r; ctl_count = c;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic set_entry(int k, logic [47:0] m, logic [7:0] t);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 5'(k); tbl_mac = m; tbl_tag = t;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic send(vec_t v);
        on = 0;
        ext_tag = v.ext;
        for (int i = 0; i < int'(v.len); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb(v, i);
            in_sof   = (i == 0);
            in_eof   = (i == int'(v.len) - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (48) @(negedge clk);
    endtask

    task automatic verify(vec_t v, bit acc, logic [7:0] tg, string rq);
        int  n;
        bit  ok;
        int  act;
        int  exp;
        n = acc ? int'(v.len) + 1 : 0;
        check(on == n, rq, "output byte count", on, n);
        if (acc && on == n) begin
            ok = 1'b1; act = 0; exp = 0;
            for (int i = 0; i < n; i++) begin
                logic [7:0] eb;
                eb = (i == n - 1) ? tg : fb(v, i);
                if (ok && (obuf[i] != eb || osof[i] != (i == 0) || oeof[i] != (i == n - 1))) begin
                    ok = 1'b0;
                    act = {osof[i], oeof[i], obuf[i]};
                    exp = {(i == 0), (i == n - 1), eb};
                end
            end
            check(ok, rq, "frame bytes, markers and tag", act, exp);
        end
    endtask

    task automatic model(vec_t v, output bit acc, output logic [7:0] tg);
        int  eff;
        bit  hit;
        eff = (v.cnt > 5'd24) ? 24 : int'(v.cnt);
        hit = 1'b0;
        tg  = v.ext;
        if (v.len >= 8'd6) begin
            for (int k = 0; k < eff; k++) begin
                if (!hit && mac_of(k) == v.mac) begin
                    hit = 1'b1;
                    tg  = tag_of(k);
                end
            end
        end
        if (hit) acc = !v.filt || !v.rej;
        else     acc = !v.filt || v.rej;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t v;
        bit   acc;
        logic [7:0] tg;
        bit   quiet;

        // R1: quiet during and after reset
        quiet = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (out_valid) quiet = 1'b0;
        end
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (out_valid) quiet = 1'b0;
        end
        check(quiet, "R1", "out_valid around reset", 0, 0);

        for (int k = 0; k < 24; k++) set_entry(k, mac_of(k), tag_of(k));

        // R1: default settings discard even a frame whose address is in the table
        v = '{1'b1, 1'b0, 5'd0, mac_of(0), 8'd8, 8'h21};
        send(v);
        verify(v, 1'b0, 8'h00, "R1");

        // Table-driven vectors
        for (int j = 0; j < NV; j++) begin
            v = VECS[j];
            set_ctl(v.filt, v.rej, v.cnt);
            model(v, acc, tg);
            send(v);
            verify(v, acc, tg, $sformatf("R%0d-vector%0d", (j < 7) ? 3 : 4, j));
        end

        // R11: a table write and a control write during a lookup are ignored
        set_ctl(1'b1, 1'b0, 5'd24);
        v = '{1'b1, 1'b0, 5'd24, mac_of(0), 8'd12, 8'h22};
        fork
            send(v);
            begin
                repeat (3) @(negedge clk);
                tbl_we = 1'b1; tbl_idx = 5'd0; tbl_mac = mac_of(0); tbl_tag = 8'hEE;
                ctl_we = 1'b1; ctl_filter_en = 1'b1; ctl_reject = 1'b1; ctl_count = 5'd0;
                @(negedge clk);
                tbl_we = 1'b0; ctl_we = 1'b0;
            end
        join
        verify(v, 1'b1, 8'h80, "R11");
        send(v);
        verify(v, 1'b1, 8'h80, "R11");

        // R11: the same write made while idle does take effect
        set_entry(0, mac_of(0), 8'hEE);
        send(v);
        verify(v, 1'b1, 8'hEE, "R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule